// File: doc/BRIEF.md
# SPI DMA Byte Pacer with Watermark and Time-out Interrupts

This block sits beside a DMA-driven SPI link, between the byte shifter and the DMA byte counter. Each time the shifter reports a finished byte, the pacer decides when the next byte may be launched. In master mode it holds the link idle for a prescaler-dependent base overhead plus a programmable number of instruction cycles. It then issues a one-cycle launch strobe.

The same 4-bit delay field has a second use. With the delay-as-interrupt bit set, it times a CPU interrupt instead of stretching the gap, and the gap shrinks to the base overhead plus one cycle. In slave mode this timer acts as a time-out that restarts on every completed byte.

A separate watermark interrupt fires once per transfer, when the remaining-byte count reported at a byte completion equals a threshold picked from a nonlinear table. All delays count instruction-cycle ticks, not raw clocks.

Top module: `spi_dma_pacer`

## Requirements
- R1: Delay code c maps to 2^c ticks for c = 0..7, to 256 + 128*(c-8) ticks for c = 8..14, and to 2048 ticks for c = 15.
- R2: The base overhead is 8 ticks for prescaler select 00 (clock/4), 9 ticks for 01 (clock/16), and 15 ticks for 10 (clock/64). Select 11 also gives 15 ticks.
- R3: In master mode with the delay-as-interrupt bit clear, a byte completion with nonzero remaining count starts a gap of base + delay ticks. The gap counts ticks in cycles after the completion cycle. launchNext pulses for one clock, one clock after the tick that completes the gap, and dlyIrq stays low.
- R4: In master mode with the delay-as-interrupt bit set, the gap is base + 1 ticks. dlyIrq pulses one clock after the delay-th tick following the completion.
- R5: In slave mode launchNext never pulses. With the delay-as-interrupt bit set, dlyIrq pulses after the selected number of ticks since the latest byte completion, and every completion restarts that count. With the bit clear, dlyIrq stays low.
- R6: A master-mode byte completion with a remaining count of 0 launches no further byte.
- R7: Timers advance only in cycles where cycTick is high.
- R8: Delay, prescaler and mode settings are captured at the byte completion. Changing them during a running interval does not alter that interval.
- R9: xferStart cancels any running gap or interrupt timer and re-arms the watermark. It takes priority over a byte completion in the same cycle.
- R10: Watermark code 0 selects 0 remaining bytes. Codes 1..7 select 2^(c-1) bytes (1 up to 64). Codes 8..15 select 128 + 64*(c-8) bytes (128 up to 576).
- R11: wmIrq pulses for one clock, in the cycle after a byte completion whose remaining count equals the selected threshold. It fires at most once between transfer starts.
- R12: A byte completion in the same cycle as a timer's final tick suppresses that expiry and restarts the timer at full length.
- R13: All three outputs are low during and right after reset and are never high two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| delaySel | input | 4 | Delay code (R1) |
| delayAsIrq | input | 1 | 1: delay field times dlyIrq; 0: delay field stretches the gap |
| wmSel | input | 4 | Watermark code (R10) |
| isMaster | input | 1 | 1: master, 0: slave |
| preSel | input | 2 | SPI clock prescaler select (R2) |
| byteDone | input | 1 | Byte-complete strobe from the shifter |
| remaining | input | REM_W | Remaining-byte count valid with byteDone |
| xferStart | input | 1 | Transfer-start strobe |
| cycTick | input | 1 | Instruction-cycle tick |
| launchNext | output | 1 | Next-byte launch strobe |
| wmIrq | output | 1 | Watermark interrupt pulse |
| dlyIrq | output | 1 | Delay / time-out interrupt pulse |

## Verification
The collision that matters is a byte completion landing in the very cycle that carries a timer's final tick. Restart and expiry then compete for the same counter. The bench provokes it by holding the tick high in the completion cycle exactly after the interval's other ticks have elapsed, in slave time-out mode and in master gap mode. The verdict is that no pulse appears one clock later and that the pulse instead appears a full interval after the colliding completion.

// File: rtl/spi_pace_pkg.sv
`timescale 1ns/1ps
package spi_pace_pkg;

  typedef struct packed {
    logic clearTimers;  // abort both timers
    logic loadGap;      // start inter-byte gap timer
    logic loadIrq;      // start interrupt / time-out timer
    logic gapShort;     // gap uses +1 instead of delay table
  } paceStrobes_t;

  function automatic int unsigned delayTicks(input logic [3:0] code);
    int unsigned c;
    c = int'(code);
    if (c <= 7) return 32'd1 << c;
    else if (c <= 14) return 256 + 128 * (c - 8);
    else return 2048;
  endfunction

  function automatic int unsigned baseTicks(input logic [1:0] pre);
    case (pre)
      2'b00:   return 8;
      2'b01:   return 9;
      default: return 15;
    endcase
  endfunction

  function automatic int unsigned wmLevel(input logic [3:0] code);
    int unsigned c;
    c = int'(code);
    if (c == 0) return 0;
    else if (c <= 7) return 32'd1 << (c - 1);
    else return 128 + 64 * (c - 8);
  endfunction

endpackage

// File: rtl/spi_pace_timer.sv
`timescale 1ns/1ps
module spi_pace_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic               clear,
  input  logic [TIMER_W-1:0] loadValue,
  input  logic               tick,
  output logic               expire
);
  logic               active;
  logic [TIMER_W-1:0] cnt;
  logic [TIMER_W-1:0] target;
  logic               lastTick;

  assign lastTick = active && tick && ((cnt + 1'b1) == target);
  assign expire   = lastTick && !load && !clear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      target <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
      target <= loadValue;
    end else if (clear) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && tick) begin
      cnt <= cnt + 1'b1;
      if (lastTick) active <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_pace_datapath.sv
`timescale 1ns/1ps
module spi_pace_datapath
  import spi_pace_pkg::*;
#(
  parameter int TIMER_W = 12,
  parameter int REM_W   = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  paceStrobes_t       strobes,
  input  logic               cycTick,
  input  logic [3:0]         delaySel,
  input  logic [1:0]         preSel,
  input  logic [3:0]         wmSel,
  input  logic [REM_W-1:0]   remaining,
  output logic               gapExpire,
  output logic               irqExpire,
  output logic               wmMatch,
  output logic               remZero
);
  localparam int N_TIMERS = 2;

  logic [TIMER_W-1:0] delayVal;
  logic [TIMER_W-1:0] gapVal;
  logic [TIMER_W-1:0] loadVals [N_TIMERS];
  logic [N_TIMERS-1:0] loads;
  logic [N_TIMERS-1:0] expires;

  assign delayVal = TIMER_W'(delayTicks(delaySel));
  assign gapVal   = TIMER_W'(baseTicks(preSel)) +
                    (strobes.gapShort ? TIMER_W'(1) : delayVal);

  assign loadVals[0] = gapVal;
  assign loadVals[1] = delayVal;
  assign loads       = {strobes.loadIrq, strobes.loadGap};

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_timer
    spi_pace_timer #(.TIMER_W(TIMER_W)) u_timer (
      .clk      (clk),
      .rstN     (rstN),
      .load     (loads[i]),
      .clear    (strobes.clearTimers),
      .loadValue(loadVals[i]),
      .tick     (cycTick),
      .expire   (expires[i])
    );
  end

  assign gapExpire = expires[0];
  assign irqExpire = expires[1];
  assign wmMatch   = (remaining == REM_W'(wmLevel(wmSel)));
  assign remZero   = (remaining == '0);
endmodule

// File: rtl/spi_pace_ctrl.sv
`timescale 1ns/1ps
module spi_pace_ctrl
  import spi_pace_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         isMaster,
  input  logic         delayAsIrq,
  input  logic         byteDone,
  input  logic         xferStart,
  input  logic         gapExpire,
  input  logic         irqExpire,
  input  logic         wmMatch,
  input  logic         remZero,
  output paceStrobes_t strobes,
  output logic         launchNext,
  output logic         wmIrq,
  output logic         dlyIrq
);
  logic wmArmed;
  logic doneLive;
  logic wmFire;

  assign doneLive = byteDone && !xferStart;
  assign wmFire   = doneLive && wmArmed && wmMatch;

  always_comb begin
    strobes             = '0;
    strobes.clearTimers = xferStart || byteDone;
    strobes.loadGap     = doneLive && isMaster && !remZero;
    strobes.loadIrq     = doneLive && delayAsIrq;
    strobes.gapShort    = delayAsIrq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wmArmed    <= 1'b1;
      launchNext <= 1'b0;
      wmIrq      <= 1'b0;
      dlyIrq     <= 1'b0;
    end else begin
      launchNext <= gapExpire;
      dlyIrq     <= irqExpire;
      wmIrq      <= wmFire;
      if (xferStart)   wmArmed <= 1'b1;
      else if (wmFire) wmArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_dma_pacer.sv
`timescale 1ns/1ps
module spi_dma_pacer
  import spi_pace_pkg::*;
#(
  parameter int TIMER_W = 12,
  parameter int REM_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       delaySel,
  input  logic             delayAsIrq,
  input  logic [3:0]       wmSel,
  input  logic             isMaster,
  input  logic [1:0]       preSel,
  input  logic             byteDone,
  input  logic [REM_W-1:0] remaining,
  input  logic             xferStart,
  input  logic             cycTick,
  output logic             launchNext,
  output logic             wmIrq,
  output logic             dlyIrq
);
  paceStrobes_t strobes;
  logic gapExpire, irqExpire, wmMatch, remZero;

  spi_pace_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .isMaster  (isMaster),
    .delayAsIrq(delayAsIrq),
    .byteDone  (byteDone),
    .xferStart (xferStart),
    .gapExpire (gapExpire),
    .irqExpire (irqExpire),
    .wmMatch   (wmMatch),
    .remZero   (remZero),
    .strobes   (strobes),
    .launchNext(launchNext),
    .wmIrq     (wmIrq),
    .dlyIrq    (dlyIrq)
  );

  spi_pace_datapath #(.TIMER_W(TIMER_W), .REM_W(REM_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cycTick  (cycTick),
    .delaySel (delaySel),
    .preSel   (preSel),
    .wmSel    (wmSel),
    .remaining(remaining),
    .gapExpire(gapExpire),
    .irqExpire(irqExpire),
    .wmMatch  (wmMatch),
    .remZero  (remZero)
  );
endmodule

// File: rtl/spi_dma_pacer_chk.sv
`timescale 1ns/1ps
module spi_dma_pacer_chk (
  input logic clk,
  input logic rstN,
  input logic byteDone,
  input logic xferStart,
  input logic cycTick,
  input logic launchNext,
  input logic wmIrq,
  input logic dlyIrq
);
  AST_LAUNCH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    launchNext |-> $past(cycTick)) else $error("launch without tick"); // R7
  AST_DLY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    dlyIrq |-> $past(cycTick)) else $error("dlyIrq without tick"); // R7
  AST_DONE_SUPPRESSES_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    launchNext |-> !$past(byteDone)) else $error("expiry not suppressed"); // R12
  AST_DONE_SUPPRESSES_DLY: assert property (@(posedge clk) disable iff (!rstN)
    dlyIrq |-> !$past(byteDone)) else $error("timeout not suppressed"); // R12
  AST_START_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (!launchNext && !dlyIrq && !wmIrq)) else $error("start did not cancel"); // R9
  AST_WM_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wmIrq |-> $past(byteDone)) else $error("watermark without byte"); // R11
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (launchNext || wmIrq || dlyIrq) |=> !(launchNext && $past(launchNext)) &&
      !(wmIrq && $past(wmIrq)) && !(dlyIrq && $past(dlyIrq))) else $error("pulse too long"); // R13
endmodule

bind spi_dma_pacer spi_dma_pacer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .byteDone  (byteDone),
  .xferStart (xferStart),
  .cycTick   (cycTick),
  .launchNext(launchNext),
  .wmIrq     (wmIrq),
  .dlyIrq    (dlyIrq)
);

// File: tb/spi_dma_pacer_tb.sv
`timescale 1ns/1ps
module spi_dma_pacer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] delaySel = '0;
  logic delayAsIrq = 1'b0;
  logic [3:0] wmSel = '0;
  logic isMaster = 1'b1;
  logic [1:0] preSel = '0;
  logic byteDone = 1'b0;
  logic [9:0] remaining = '0;
  logic xferStart = 1'b0;
  logic cycTick = 1'b0;
  logic launchNext, wmIrq, dlyIrq;

  int nChecks = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  spi_dma_pacer u_dut (
    .clk(clk), .rstN(rstN), .delaySel(delaySel), .delayAsIrq(delayAsIrq),
    .wmSel(wmSel), .isMaster(isMaster), .preSel(preSel), .byteDone(byteDone),
    .remaining(remaining), .xferStart(xferStart), .cycTick(cycTick),
    .launchNext(launchNext), .wmIrq(wmIrq), .dlyIrq(dlyIrq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one byte completion, then records the first cycle (0 = cycle
  // right after the completion edge) at which each output is seen high.
  task automatic watch(input int limit, input int period, input bit tick0,
                       input int altDelay, output int la, output int dl,
                       output int wm, output int wmN);
    la = -1; dl = -1; wm = -1; wmN = 0;
    @(negedge clk);
    byteDone = 1'b1; cycTick = tick0;
    @(posedge clk); @(negedge clk);
    byteDone = 1'b0; cycTick = 1'b0;
    if (launchNext) la = 0;
    if (dlyIrq) dl = 0;
    if (wmIrq) begin wm = 0; wmN++; end
    for (int k = 1; k <= limit; k++) begin
      cycTick = (k % period == 0);
      if (k == 2 && altDelay >= 0) delaySel = 4'(altDelay);
      @(posedge clk); @(negedge clk);
      if (launchNext && la < 0) la = k;
      if (dlyIrq && dl < 0) dl = k;
      if (wmIrq) begin if (wm < 0) wm = k; wmN++; end
    end
    cycTick = 1'b0;
  endtask

  task automatic startXfer();
    @(negedge clk); xferStart = 1'b1;
    @(posedge clk); @(negedge clk); xferStart = 1'b0;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    chk("R13 launch in reset", int'(launchNext), 0);
    chk("R13 irqs in reset", int'(wmIrq | dlyIrq), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 outputs after reset", int'(launchNext | wmIrq | dlyIrq), 0);
  endtask

  task automatic tMasterGap();
    int la, dl, wm, wmN;
    int sels [7] = '{3, 0, 9, 15, 14, 7, 12};
    int pres [7] = '{0, 1, 2, 0, 3, 1, 0};
    int exps [7] = '{16, 10, 399, 2056, 1039, 137, 776};
    isMaster = 1'b1; delayAsIrq = 1'b0; remaining = 10'd5; wmSel = 4'd0;
    for (int i = 0; i < 7; i++) begin
      delaySel = 4'(sels[i]); preSel = 2'(pres[i]);
      watch(exps[i] + 5, 1, 1'b0, -1, la, dl, wm, wmN);
      chk("R3 R1 R2 master gap", la, exps[i]);
      chk("R3 no dlyIrq in gap mode", dl, -1);
    end
  endtask

  task automatic tMasterIrq();
    int la, dl, wm, wmN;
    isMaster = 1'b1; delayAsIrq = 1'b1; remaining = 10'd5;
    delaySel = 4'd4; preSel = 2'd0;
    watch(30, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R4 short gap div4", la, 9);
    chk("R4 dlyIrq 16", dl, 16);
    delaySel = 4'd8; preSel = 2'd2;
    watch(270, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R4 short gap div64", la, 16);
    chk("R4 dlyIrq 256", dl, 256);
  endtask

  task automatic tSlave();
    int la, dl, wm, wmN;
    isMaster = 1'b0; delayAsIrq = 1'b1; delaySel = 4'd2; remaining = 10'd5;
    watch(40, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R5 slave timeout 4", dl, 4);
    chk("R5 slave never launches", la, -1);
    delayAsIrq = 1'b0;
    watch(40, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R5 slave timeout disabled", dl, -1);
    chk("R5 slave never launches", la, -1);
    delayAsIrq = 1'b1; delaySel = 4'd3;
    watch(5, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R5 no timeout before 8", dl, -1);
    watch(20, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R5 timeout restarts on byte", dl, 8);
  endtask

  task automatic tCollision();
    int la, dl, wm, wmN;
    isMaster = 1'b0; delayAsIrq = 1'b1; delaySel = 4'd3; remaining = 10'd5;
    watch(7, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R12 no early timeout", dl, -1);
    watch(20, 1, 1'b1, -1, la, dl, wm, wmN);
    chk("R12 timeout collision restarts", dl, 8);
    isMaster = 1'b1; delayAsIrq = 1'b0; delaySel = 4'd0; preSel = 2'd0;
    watch(8, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R12 no early launch", la, -1);
    watch(20, 1, 1'b1, -1, la, dl, wm, wmN);
    chk("R12 gap collision restarts", la, 9);
  endtask

  task automatic tRemZero();
    int la, dl, wm, wmN;
    startXfer();
    isMaster = 1'b1; delayAsIrq = 1'b0; delaySel = 4'd0; preSel = 2'd0;
    remaining = 10'd0; wmSel = 4'd0;
    watch(30, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R6 no launch at zero remaining", la, -1);
    chk("R10 code 0 fires at zero", wm, 0);
  endtask

  task automatic tTick();
    int la, dl, wm, wmN;
    isMaster = 1'b1; delayAsIrq = 1'b0; delaySel = 4'd1; preSel = 2'd0;
    remaining = 10'd5;
    watch(50, 4, 1'b0, -1, la, dl, wm, wmN);
    chk("R7 gap counts ticks only", la, 40);
  endtask

  task automatic tLatch();
    int la, dl, wm, wmN;
    isMaster = 1'b1; delayAsIrq = 1'b0; delaySel = 4'd5; preSel = 2'd0;
    remaining = 10'd5;
    watch(60, 1, 1'b0, 15, la, dl, wm, wmN);
    chk("R8 delay latched at byte", la, 40);
  endtask

  task automatic tStart();
    int la, dl, wm, wmN;
    int seen;
    isMaster = 1'b1; delayAsIrq = 1'b1; delaySel = 4'd4; preSel = 2'd0;
    remaining = 10'd5;
    watch(3, 1, 1'b0, -1, la, dl, wm, wmN);
    seen = 0;
    @(negedge clk); xferStart = 1'b1; cycTick = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk); @(negedge clk);
      xferStart = 1'b0;
      if (launchNext | dlyIrq) seen++;
    end
    cycTick = 1'b0;
    chk("R9 start cancels timers", seen, 0);
  endtask

  task automatic tWatermark();
    int la, dl, wm, wmN;
    isMaster = 1'b0; delayAsIrq = 1'b0;
    startXfer();
    wmSel = 4'd7; remaining = 10'd64;
    watch(4, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 code 7 is 64", wm, 0);
    chk("R11 single-cycle pulse", wmN, 1);
    watch(4, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R11 once per transfer", wm, -1);
    startXfer();
    remaining = 10'd65;
    watch(4, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 65 does not match code 7", wm, -1);
    remaining = 10'd64;
    watch(4, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R9 start re-arms watermark", wm, 0);
    startXfer(); wmSel = 4'd15; remaining = 10'd576;
    watch(2, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 code 15 is 576", wm, 0);
    startXfer(); wmSel = 4'd8; remaining = 10'd128;
    watch(2, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 code 8 is 128", wm, 0);
    startXfer(); wmSel = 4'd3; remaining = 10'd4;
    watch(2, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 code 3 is 4", wm, 0);
    startXfer(); wmSel = 4'd1; remaining = 10'd1;
    watch(2, 1, 1'b0, -1, la, dl, wm, wmN);
    chk("R10 code 1 is 1", wm, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog R13 actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    tReset();
    tMasterGap();
    tMasterIrq();
    tSlave();
    tCollision();
    tRemZero();
    tTick();
    tLatch();
    tStart();
    tWatermark();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule